// File: doc/BRIEF.md
# Doorbell-Driven Receive Frame Scanner

This block sorts a batch of received Ethernet frames for a low-latency trading path. Software writes a doorbell that gives the index of the first receive descriptor and the number of frames in the batch. The block then follows the descriptor chain through each descriptor's next pointer. For every frame it reads three header words from frame memory and decides whether the frame is an IPv4/UDP datagram addressed to the programmed trading port.

A matching frame is announced to the downstream packet processor with a one-cycle strobe that carries its descriptor index and buffer address. Its descriptor index is also appended to a small recycling queue, which software drains. Every other frame, such as ARP or management traffic, is skipped. The block has no write port into descriptor or frame memory, so ownership bits and buffer contents are never changed. Software releases frames through the queue.

When the last frame of the batch has been judged, the block pulses a completion interrupt. In the same cycle it shows how many frames of that batch it took and how many it left for software. A doorbell that arrives while a batch is still running is dropped and raises a sticky error flag.

Top module: `udp_rx_scanner`

## Requirements
- R1: After reset `busy`, `done_irq`, `db_err`, `rq_valid`, both status counts and both memory read enables are 0. While idle, no memory read is issued. A doorbell accepted while idle makes `busy` 1 from the next cycle.
- R2: The scanner reads exactly `db_count` descriptors. It starts at `db_first` and takes each following index from the next-pointer field of the descriptor just read.
- R3: A descriptor word holds the buffer word address in bits [BUF_AW-1:0], the next index in bits [BUF_AW+IDX_W-1:BUF_AW] and the ownership bit in the top bit. For each frame, header words are read at buffer address +3, +5 and +9, in that order.
- R4: A frame matches when all of these hold: word +3 bits [31:16] equal 0x0800, word +3 bits [15:8] equal 0x45, word +5 bits [7:0] equal 17, and word +9 bits [31:16] equal `udp_port`. All other bits are ignored.
- R5: A matching frame whose ownership bit is 1 produces one `pp_valid` pulse with its index and buffer address. Its index enters the recycling queue. Queue output order equals frame order.
- R6: A frame that does not match, or whose ownership bit is 0, produces no `pp_valid` pulse and no queue entry. Descriptor and frame memory are never written.
- R7: When the recycling queue (RQ_DEPTH entries) is full, the scanner waits and loses no index. A pop and a push in the same cycle on a full queue are both accepted.
- R8: `done_irq` pulses for exactly one cycle per accepted doorbell, after the last frame is judged, with `busy` already 0. A doorbell with count 0 gives the pulse two cycles after the doorbell cycle.
- R9: A doorbell while `busy` is 1 is ignored. `db_err` becomes 1 in the next cycle and stays 1 until reset.
- R10: In the cycle of `done_irq`, `stat_udp` and `stat_sw` hold the number of frames taken and left in that batch. Their sum equals the doorbell count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Doorbell write strobe |
| db_first | input | IDX_W | First descriptor index of the batch |
| db_count | input | CNT_W | Number of frames in the batch |
| udp_port | input | 16 | Trading UDP destination port |
| desc_rd_en | output | 1 | Descriptor memory read enable |
| desc_rd_idx | output | IDX_W | Descriptor index to read |
| desc_rd_data | input | 1+IDX_W+BUF_AW | Descriptor word, one cycle after the enable |
| frm_rd_en | output | 1 | Frame memory read enable |
| frm_rd_addr | output | BUF_AW | Frame memory word address |
| frm_rd_data | input | 32 | Frame word, one cycle after the enable |
| pp_valid | output | 1 | Frame handed to the packet processor |
| pp_idx | output | IDX_W | Descriptor index of the handed frame |
| pp_buf | output | BUF_AW | Buffer address of the handed frame |
| rq_valid | output | 1 | Recycling queue not empty |
| rq_idx | output | IDX_W | Index at the queue head |
| rq_pop | input | 1 | Software removes the queue head |
| done_irq | output | 1 | Batch completion pulse |
| busy | output | 1 | Batch in progress |
| db_err | output | 1 | Sticky flag for a doorbell rejected while busy |
| stat_udp | output | CNT_W | Frames taken in the last batch |
| stat_sw | output | CNT_W | Frames left for software in the last batch |

## Verification
Two events can fall in the same cycle: the scanner pushing a matching frame's index into the recycling queue, and software popping the queue head. The bench sends a batch of six matching frames without popping, so the four-entry queue fills and the scanner waits with a fifth frame ready. It then raises a single pop. The fifth `pp_valid` pulse must appear in that same cycle. The full popped sequence must list all six indices in chain order, with none lost or duplicated.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  localparam int          HDR_DW        = 32;
  localparam logic [15:0] ETYPE_IPV4    = 16'h0800;
  localparam logic [7:0]  VER_IHL_PLAIN = 8'h45;
  localparam logic [7:0]  PROTO_UDP     = 8'd17;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC, ST_DWAIT, ST_HDR, ST_HWAIT, ST_CLASS, ST_PUSH, ST_DONE
  } scan_st_e;

  // Word offset inside a frame buffer of each header word that is read.
  function automatic logic [3:0] hdr_word_off(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd3;   // EtherType and IP version/length byte
      2'd1:    return 4'd5;   // IP protocol byte in the low lane
      default: return 4'd9;   // UDP destination port in the high half
    endcase
  endfunction

  // Masked comparison of the three captured header words.
  function automatic logic is_trading_udp(input logic [HDR_DW-1:0] w_eth,
                                          input logic [HDR_DW-1:0] w_ip,
                                          input logic [HDR_DW-1:0] w_l4,
                                          input logic [15:0]       port);
    logic eth_ok, ip_ok, l4_ok;
    eth_ok = (w_eth & 32'hFFFF_FF00) == {ETYPE_IPV4, VER_IHL_PLAIN, 8'h00};
    ip_ok  = (w_ip  & 32'h0000_00FF) == {24'h0, PROTO_UDP};
    l4_ok  = (w_l4  & 32'hFFFF_0000) == {port, 16'h0000};
    return eth_ok && ip_ok && l4_ok;
  endfunction

endpackage

// File: rtl/rfs_recycle_fifo.sv
module rfs_recycle_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic                         valid,
  output logic [W-1:0]                 dout,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_pop, do_push;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign do_pop  = pop && (cnt != '0);
  assign do_push = push && ((cnt != LW'(DEPTH)) || do_pop);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wp == PW'(g))) slot[g] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + LW'(1);
        2'b01:   cnt <= cnt - LW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign valid = (cnt != '0);
  assign dout  = slot[rp];
  assign full  = (cnt == LW'(DEPTH));
  assign level = cnt;

endmodule

// File: rtl/rfs_hdr_unit.sv
module rfs_hdr_unit
  import rfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [1:0]        sel,
  input  logic [HDR_DW-1:0] word,
  input  logic [15:0]       port,
  output logic              match
);
  logic [HDR_DW-1:0] w_eth, w_ip, w_l4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_eth <= '0;
      w_ip  <= '0;
      w_l4  <= '0;
    end else if (cap) begin
      case (sel)
        2'd0:    w_eth <= word;
        2'd1:    w_ip  <= word;
        default: w_l4  <= word;
      endcase
    end
  end

  assign match = is_trading_udp(w_eth, w_ip, w_l4, port);

endmodule

// File: rtl/rfs_walk_ctrl.sv
module rfs_walk_ctrl
  import rfs_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int BUF_AW = 12,
  parameter int CNT_W  = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         db_valid,
  input  logic [IDX_W-1:0]             db_first,
  input  logic [CNT_W-1:0]             db_count,
  output logic                         desc_rd_en,
  output logic [IDX_W-1:0]             desc_rd_idx,
  input  logic [BUF_AW+IDX_W:0]        desc_rd_data,
  output logic                         frm_rd_en,
  output logic [BUF_AW-1:0]            frm_rd_addr,
  output logic                         hdr_cap,
  output logic [1:0]                   hdr_sel,
  input  logic                         hdr_match,
  input  logic                         can_push,
  output logic                         take,
  output logic [IDX_W-1:0]             take_idx,
  output logic [BUF_AW-1:0]            take_buf,
  output logic                         done_irq,
  output logic                         busy,
  output logic                         db_err,
  output logic [CNT_W-1:0]             stat_udp,
  output logic [CNT_W-1:0]             stat_sw,
  output logic                         frame_end
);
  typedef struct packed {
    logic              own;
    logic [IDX_W-1:0]  nxt;
    logic [BUF_AW-1:0] baddr;
  } desc_t;

  scan_st_e         st;
  desc_t            cur_d;
  logic [IDX_W-1:0] cur_idx;
  logic [CNT_W-1:0] left, n_udp, n_sw;
  logic [1:0]       sel;
  logic             skip;

  assign skip      = (st == ST_CLASS) && !(hdr_match && cur_d.own);
  assign take      = (st == ST_PUSH) && can_push;
  assign frame_end = take || skip;

  assign desc_rd_en  = (st == ST_DESC);
  assign desc_rd_idx = cur_idx;
  assign frm_rd_en   = (st == ST_HDR);
  assign frm_rd_addr = cur_d.baddr + BUF_AW'(hdr_word_off(sel));
  assign hdr_cap     = (st == ST_HWAIT);
  assign hdr_sel     = sel;
  assign take_idx    = cur_idx;
  assign take_buf    = cur_d.baddr;
  assign busy        = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_d    <= '0;
      cur_idx  <= '0;
      left     <= '0;
      n_udp    <= '0;
      n_sw     <= '0;
      sel      <= '0;
      done_irq <= 1'b0;
      db_err   <= 1'b0;
      stat_udp <= '0;
      stat_sw  <= '0;
    end else begin
      done_irq <= 1'b0;
      if (db_valid && (st != ST_IDLE)) db_err <= 1'b1;
      case (st)
        ST_IDLE: if (db_valid) begin
          cur_idx <= db_first;
          left    <= db_count;
          n_udp   <= '0;
          n_sw    <= '0;
          st      <= (db_count == '0) ? ST_DONE : ST_DESC;
        end
        ST_DESC:  st <= ST_DWAIT;
        ST_DWAIT: begin
          cur_d <= desc_t'(desc_rd_data);
          sel   <= 2'd0;
          st    <= ST_HDR;
        end
        ST_HDR:   st <= ST_HWAIT;
        ST_HWAIT: begin
          if (sel == 2'd2) st <= ST_CLASS;
          else begin
            sel <= sel + 2'd1;
            st  <= ST_HDR;
          end
        end
        ST_CLASS: if (!skip) st <= ST_PUSH;
        ST_PUSH:  ;
        ST_DONE: begin
          done_irq <= 1'b1;
          stat_udp <= n_udp;
          stat_sw  <= n_sw;
          st       <= ST_IDLE;
        end
        default:  st <= ST_IDLE;
      endcase
      if (frame_end) begin
        if (take) n_udp <= n_udp + CNT_W'(1);
        else      n_sw  <= n_sw + CNT_W'(1);
        left <= left - CNT_W'(1);
        if (left == CNT_W'(1)) st <= ST_DONE;
        else begin
          cur_idx <= cur_d.nxt;
          st      <= ST_DESC;
        end
      end
    end
  end

endmodule

// File: rtl/udp_rx_scanner.sv
module udp_rx_scanner
  import rfs_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int BUF_AW   = 12,
  parameter int CNT_W    = 7,
  parameter int RQ_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      db_valid,
  input  logic [IDX_W-1:0]          db_first,
  input  logic [CNT_W-1:0]          db_count,
  input  logic [15:0]               udp_port,
  output logic                      desc_rd_en,
  output logic [IDX_W-1:0]          desc_rd_idx,
  input  logic [BUF_AW+IDX_W:0]     desc_rd_data,
  output logic                      frm_rd_en,
  output logic [BUF_AW-1:0]         frm_rd_addr,
  input  logic [HDR_DW-1:0]         frm_rd_data,
  output logic                      pp_valid,
  output logic [IDX_W-1:0]          pp_idx,
  output logic [BUF_AW-1:0]         pp_buf,
  output logic                      rq_valid,
  output logic [IDX_W-1:0]          rq_idx,
  input  logic                      rq_pop,
  output logic                      done_irq,
  output logic                      busy,
  output logic                      db_err,
  output logic [CNT_W-1:0]          stat_udp,
  output logic [CNT_W-1:0]          stat_sw
);
  localparam int RQ_LVL_W = $clog2(RQ_DEPTH+1);

  // Internal events, named for the checker.
  logic                rq_push;
  logic                rq_full;
  logic [RQ_LVL_W-1:0] rq_level;
  logic                can_push;
  logic                hdr_cap, hdr_match;
  logic [1:0]          hdr_sel;
  logic                ev_frame_end;

  assign can_push = !rq_full || rq_pop;
  assign pp_valid = rq_push;

  rfs_walk_ctrl #(.IDX_W(IDX_W), .BUF_AW(BUF_AW), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .db_valid(db_valid), .db_first(db_first), .db_count(db_count),
    .desc_rd_en(desc_rd_en), .desc_rd_idx(desc_rd_idx), .desc_rd_data(desc_rd_data),
    .frm_rd_en(frm_rd_en), .frm_rd_addr(frm_rd_addr),
    .hdr_cap(hdr_cap), .hdr_sel(hdr_sel), .hdr_match(hdr_match),
    .can_push(can_push),
    .take(rq_push), .take_idx(pp_idx), .take_buf(pp_buf),
    .done_irq(done_irq), .busy(busy), .db_err(db_err),
    .stat_udp(stat_udp), .stat_sw(stat_sw),
    .frame_end(ev_frame_end)
  );

  rfs_hdr_unit u_hdr (
    .clk(clk), .rst_n(rst_n),
    .cap(hdr_cap), .sel(hdr_sel), .word(frm_rd_data), .port(udp_port),
    .match(hdr_match)
  );

  rfs_recycle_fifo #(.W(IDX_W), .DEPTH(RQ_DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_n),
    .push(rq_push), .din(pp_idx), .pop(rq_pop),
    .valid(rq_valid), .dout(rq_idx), .full(rq_full), .level(rq_level)
  );

endmodule

// File: rtl/udp_rx_scanner_chk.sv
module udp_rx_scanner_chk #(
  parameter int RQ_DEPTH = 4,
  parameter int LVL_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             db_valid,
  input logic             busy,
  input logic             db_err,
  input logic             done_irq,
  input logic             desc_rd_en,
  input logic             frm_rd_en,
  input logic             pp_valid,
  input logic             rq_push,
  input logic             rq_full,
  input logic             rq_pop,
  input logic [LVL_W-1:0] rq_level,
  input logic             ev_frame_end
);
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(desc_rd_en || frm_rd_en));

  a_r2_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_rd_en, frm_rd_en, pp_valid}));

  a_r5_push_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rq_push |-> ev_frame_end);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rq_push |-> (!rq_full || rq_pop));

  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rq_level <= LVL_W'(RQ_DEPTH));

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  a_r8_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy);

  a_r9_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && busy) |=> db_err);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    db_err |=> db_err);
endmodule

bind udp_rx_scanner udp_rx_scanner_chk #(.RQ_DEPTH(RQ_DEPTH), .LVL_W(RQ_LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .busy(busy), .db_err(db_err),
  .done_irq(done_irq), .desc_rd_en(desc_rd_en), .frm_rd_en(frm_rd_en),
  .pp_valid(pp_valid), .rq_push(rq_push), .rq_full(rq_full), .rq_pop(rq_pop),
  .rq_level(rq_level), .ev_frame_end(ev_frame_end)
);

// File: tb/udp_rx_scanner_tb.sv
module udp_rx_scanner_tb;
  localparam int IDX_W = 6, BUF_AW = 12, CNT_W = 7, RQ_DEPTH = 4;
  localparam int DESC_W = 1 + IDX_W + BUF_AW;
  localparam logic [15:0] PORT_A = 16'd15000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic db_valid = 1'b0;
  logic [IDX_W-1:0] db_first = '0;
  logic [CNT_W-1:0] db_count = '0;
  logic [15:0] udp_port = PORT_A;
  logic desc_rd_en, frm_rd_en, pp_valid, rq_valid, done_irq, busy, db_err;
  logic rq_pop = 1'b0;
  logic [IDX_W-1:0] desc_rd_idx, pp_idx, rq_idx;
  logic [DESC_W-1:0] desc_rd_data = '0;
  logic [BUF_AW-1:0] frm_rd_addr, pp_buf;
  logic [31:0] frm_rd_data = '0;
  logic [CNT_W-1:0] stat_udp, stat_sw;

  udp_rx_scanner #(.IDX_W(IDX_W), .BUF_AW(BUF_AW), .CNT_W(CNT_W), .RQ_DEPTH(RQ_DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_first(db_first), .db_count(db_count),
    .udp_port(udp_port), .desc_rd_en(desc_rd_en), .desc_rd_idx(desc_rd_idx),
    .desc_rd_data(desc_rd_data), .frm_rd_en(frm_rd_en), .frm_rd_addr(frm_rd_addr),
    .frm_rd_data(frm_rd_data), .pp_valid(pp_valid), .pp_idx(pp_idx), .pp_buf(pp_buf),
    .rq_valid(rq_valid), .rq_idx(rq_idx), .rq_pop(rq_pop), .done_irq(done_irq),
    .busy(busy), .db_err(db_err), .stat_udp(stat_udp), .stat_sw(stat_sw)
  );

  // Memory models with one-cycle read latency.
  logic [DESC_W-1:0] dmem [0:63];
  logic [31:0]       fmem [0:4095];
  always @(posedge clk) begin
    if (desc_rd_en) desc_rd_data <= dmem[desc_rd_idx];
    if (frm_rd_en)  frm_rd_data  <= fmem[frm_rd_addr];
  end

  // Output monitors, sampled mid low phase.
  int pp_n = 0, desc_n = 0, frm_n = 0, irq_n = 0, pop_n = 0;
  logic [IDX_W-1:0]  pp_idx_log [0:255];
  logic [BUF_AW-1:0] pp_buf_log [0:255];
  logic [IDX_W-1:0]  desc_log   [0:255];
  logic [BUF_AW-1:0] frm_log    [0:1023];
  logic [IDX_W-1:0]  pop_log    [0:255];
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (pp_valid)   begin pp_idx_log[pp_n % 256] = pp_idx; pp_buf_log[pp_n % 256] = pp_buf; pp_n++; end
      if (desc_rd_en) begin desc_log[desc_n % 256] = desc_rd_idx; desc_n++; end
      if (frm_rd_en)  begin frm_log[frm_n % 1024] = frm_rd_addr; frm_n++; end
      if (done_irq)   irq_n++;
    end
  end

  int checks = 0, fails = 0;
  task automatic check_eq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_frame(input int idx, input int baddr, input int nxt, input bit own,
                           input logic [15:0] etype, input logic [7:0] vihl,
                           input logic [7:0] proto, input logic [15:0] dport);
    dmem[idx] = {own, IDX_W'(nxt), BUF_AW'(baddr)};
    fmem[baddr+3] = {etype, vihl, 8'h5A};
    fmem[baddr+5] = {24'hC3A5_11, proto};
    fmem[baddr+9] = {dport, 16'h9E21};
  endtask

  task automatic ring(input int first, input int count);
    @(negedge clk);
    db_valid = 1'b1; db_first = IDX_W'(first); db_count = CNT_W'(count);
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic wait_done(input int base);
    int guard = 0;
    while (irq_n == base && guard < 2000) begin @(negedge clk); #3; guard++; end
  endtask

  task automatic pop_one();
    @(negedge clk);
    if (rq_valid) begin
      pop_log[pop_n % 256] = rq_idx; pop_n++;
      rq_pop = 1'b1;
      @(negedge clk);
      rq_pop = 1'b0;
    end
  endtask

  task automatic drain();
    int guard = 0;
    while ((rq_valid || busy) && guard < 400) begin pop_one(); repeat (2) @(negedge clk); guard++; end
  endtask

  task automatic t_reset();
    @(negedge clk); #3;
    check_eq("R1", "busy after reset", busy, 0);
    check_eq("R1", "irq after reset", done_irq, 0);
    check_eq("R1", "db_err after reset", db_err, 0);
    check_eq("R1", "rq_valid after reset", rq_valid, 0);
    check_eq("R1", "stats after reset", {stat_udp, stat_sw}, 0);
    check_eq("R1", "reads after reset", {desc_rd_en, frm_rd_en}, 0);
  endtask

  task automatic t_mixed();
    int pb = pp_n, db = desc_n, fb = frm_n, ib = irq_n, qb = pop_n;
    logic [DESC_W-1:0] d9;
    put_frame(5, 100, 9, 1, 16'h0800, 8'h45, 8'd17, PORT_A);
    put_frame(9, 200, 2, 1, 16'h0806, 8'h45, 8'd17, PORT_A);
    put_frame(2, 300, 30, 1, 16'h0800, 8'h45, 8'd17, PORT_A + 16'd1);
    put_frame(30, 400, 7, 1, 16'h0800, 8'h45, 8'd17, PORT_A);
    d9 = dmem[9];
    ring(5, 4);
    #3 check_eq("R1", "busy after doorbell", busy, 1);
    wait_done(ib);
    check_eq("R2", "descriptor reads", desc_n - db, 4);
    check_eq("R2", "chain 0", desc_log[db % 256], 5);
    check_eq("R2", "chain 1", desc_log[(db+1) % 256], 9);
    check_eq("R2", "chain 2", desc_log[(db+2) % 256], 2);
    check_eq("R2", "chain 3", desc_log[(db+3) % 256], 30);
    check_eq("R3", "hdr addr 0", frm_log[fb % 1024], 103);
    check_eq("R3", "hdr addr 1", frm_log[(fb+1) % 1024], 105);
    check_eq("R3", "hdr addr 2", frm_log[(fb+2) % 1024], 109);
    check_eq("R5", "handoffs", pp_n - pb, 2);
    check_eq("R5", "handoff idx 0", pp_idx_log[pb % 256], 5);
    check_eq("R5", "handoff buf 0", pp_buf_log[pb % 256], 100);
    check_eq("R5", "handoff idx 1", pp_idx_log[(pb+1) % 256], 30);
    check_eq("R5", "handoff buf 1", pp_buf_log[(pb+1) % 256], 400);
    check_eq("R10", "stat_udp", stat_udp, 2);
    check_eq("R10", "stat_sw", stat_sw, 2);
    check_eq("R8", "busy at irq", busy, 0);
    repeat (5) @(negedge clk); #3;
    check_eq("R8", "irq count", irq_n - ib, 1);
    check_eq("R6", "arp descriptor unchanged", dmem[9], d9);
    drain();
    check_eq("R5", "queue entries", pop_n - qb, 2);
    check_eq("R5", "queue order 0", pop_log[qb % 256], 5);
    check_eq("R5", "queue order 1", pop_log[(qb+1) % 256], 30);
  endtask

  task automatic t_corners();
    int pb = pp_n, ib = irq_n, qb = pop_n;
    put_frame(10, 500, 11, 1, 16'h0800, 8'h46, 8'd17, PORT_A);
    put_frame(11, 600, 12, 1, 16'h0800, 8'h45, 8'd6,  PORT_A);
    put_frame(12, 700, 13, 0, 16'h0800, 8'h45, 8'd17, PORT_A);
    put_frame(13, 800, 0,  1, 16'h0800, 8'h45, 8'd17, PORT_A);
    ring(10, 4);
    wait_done(ib);
    check_eq("R4", "only plain udp taken", pp_n - pb, 1);
    check_eq("R6", "owned-by-dma frame skipped", pp_idx_log[pb % 256], 13);
    check_eq("R10", "corner stats", {stat_udp, stat_sw}, {CNT_W'(1), CNT_W'(3)});
    drain();
    check_eq("R6", "no queue entry for skipped", pop_n - qb, 1);
  endtask

  task automatic t_port();
    int pb = pp_n, ib = irq_n;
    udp_port = PORT_A + 16'd1;
    ring(2, 1);
    wait_done(ib);
    check_eq("R4", "reprogrammed port match", pp_n - pb, 1);
    check_eq("R4", "reprogrammed port idx", pp_idx_log[pb % 256], 2);
    udp_port = PORT_A;
    drain();
  endtask

  task automatic t_full();
    int pb = pp_n, ib = irq_n, qb = pop_n;
    for (int k = 0; k < 6; k++)
      put_frame(40 + k, 1000 + 16*k, 41 + k, 1, 16'h0800, 8'h45, 8'd17, PORT_A);
    ring(40, 6);
    repeat (80) @(negedge clk); #3;
    check_eq("R7", "handoffs while full", pp_n - pb, 4);
    check_eq("R7", "still busy while full", busy, 1);
    check_eq("R7", "no irq while stalled", irq_n - ib, 0);
    pop_one();
    #3;
    check_eq("R7", "push in pop cycle", pp_n - pb, 5);
    drain();
    wait_done(ib);
    check_eq("R7", "all indices recycled", pop_n - qb, 6);
    for (int k = 0; k < 6; k++)
      check_eq("R7", "recycle order", pop_log[(qb+k) % 256], 40 + k);
    check_eq("R10", "full stats", {stat_udp, stat_sw}, {CNT_W'(6), CNT_W'(0)});
  endtask

  task automatic t_busy_db();
    int db = desc_n, ib = irq_n;
    for (int k = 0; k < 3; k++)
      put_frame(50 + k, 2000 + 16*k, 51 + k, 1, 16'h0806, 8'h00, 8'd0, 16'd0);
    @(negedge clk); #3;
    check_eq("R9", "db_err clear before", db_err, 0);
    ring(50, 3);
    ring(5, 4);
    #3 check_eq("R9", "db_err set", db_err, 1);
    wait_done(ib);
    check_eq("R9", "first set stats", {stat_udp, stat_sw}, {CNT_W'(0), CNT_W'(3)});
    repeat (60) @(negedge clk); #3;
    check_eq("R9", "second doorbell ignored", desc_n - db, 3);
    check_eq("R8", "one irq for the set", irq_n - ib, 1);
    check_eq("R9", "db_err sticky", db_err, 1);
  endtask

  task automatic t_zero();
    int db = desc_n, ib = irq_n;
    ring(0, 0);
    // ring returns at the negedge after the doorbell edge; one more edge raises irq.
    @(negedge clk); #3;
    check_eq("R8", "zero count irq timing", done_irq, 1);
    repeat (3) @(negedge clk); #3;
    check_eq("R8", "zero count irq once", irq_n - ib, 1);
    check_eq("R10", "zero count stats", {stat_udp, stat_sw}, 0);
    check_eq("R2", "zero count reads", desc_n - db, 0);
  endtask

  bit finished = 1'b0;
  initial begin
    for (int i = 0; i < 4096; i++) fmem[i] = 32'h0;
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mixed();
    t_corners();
    t_port();
    t_full();
    t_zero();
    t_busy_db();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule